// File: doc/BRIEF.md
# Sparse Ling Parallel-Prefix Adder

A combinational binary adder for wide operands, 64 bits by default. It adds two operands and a carry input and returns the sum and a carry output. The carry network is a radix-2 parallel-prefix tree. It works on Ling pseudo-carries, and it produces a carry only at the first bit of each group of `SPARSE` bits. Each group builds two candidate sums ahead of time: one that assumes no carry enters the group, and one that assumes a carry does. The recovered true carry entering the group then picks one of the two.

Inside a group, the candidate sums come from a small prefix network rather than a ripple chain. The sum side therefore takes about 2 + log2(SPARSE) levels, while the carry side takes log2(WIDTH) levels. For this reason `SPARSE` is limited to 1, 2, 4 or 8 and must not exceed WIDTH/4. `WIDTH` must be a power of two. Elaboration rejects any other setting.

The `TREE` parameter picks the topology of the carry tree. Value 0 is a Kogge-Stone style tree: every node drives at most two nodes, and wiring is heavier. Value 1 is a Ladner-Fischer style divide-in-half tree: wiring is light, and fan-out grows to half the span. Both reach the minimum number of prefix levels. Both are used the same way: drive the inputs, and read the outputs after the combinational delay.

Top module: `sla_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i` for every input combination, with no clock involved.
- R2: `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`. Examples: all-ones plus zero plus carry-in 1 gives `cout_o`=1 and `sum_o`=0.
- R3: With both operands zero, `sum_o` equals `cin_i` in bit 0 with all other bits 0, and `cout_o` is 0.
- R4: When `b_i` is the bitwise complement of `a_i`, the result is all ones with `cout_o`=0 if `cin_i`=0, and all zeros with `cout_o`=1 if `cin_i`=1.
- R5: A carry generated below any group boundary propagates through that boundary. Adding 1 to an operand whose low k·SPARSE bits are ones gives exactly 2^(k·SPARSE) for every k.
- R6: Sparseness values 1, 2, 4 and 8 give the same sum and carry output for the same inputs.
- R7: Tree selection 0 (Kogge-Stone) and 1 (Ladner-Fischer) give the same sum and carry output for the same inputs.
- R8: A narrow instance (WIDTH=8, SPARSE=2) is correct for all 2^17 input combinations in both tree styles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | first operand |
| b_i | input | WIDTH | second operand |
| cin_i | input | 1 | carry into bit 0 |
| sum_o | output | WIDTH | low WIDTH bits of the sum |
| cout_o | output | 1 | carry out of the top bit |

## Verification
The 64-bit instances are driven with these patterns:
- Complementary operands, which make every bit propagate. They show whether the pseudo-carry recovery chains propagate terms across the whole width without dropping or inventing a carry.
- Operands of low ones plus one. These isolate each group boundary in turn, so a wrong select or a wrong recovery term at one group shows as one misplaced bit.
- All-zero operands with either carry-in. These show whether the carry-in reaches only bit 0 and stays out of the carry output.
- Random operands and a fixed table. These compare every sparseness and both tree styles against the arithmetic sum.

A narrow adder is then swept through every input, which covers every group-select combination in both topologies.

// File: rtl/sla_pkg.sv
package sla_pkg;
    localparam int TREE_KS = 0;
    localparam int TREE_LF = 1;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    function automatic gp_t gp_join(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction
endpackage

// File: rtl/sla_prefix.sv
module sla_prefix
    import sla_pkg::*;
#(
    parameter int W    = 4,
    parameter int TREE = TREE_KS
) (
    input  logic [W-1:0] g_i,
    input  logic [W-1:0] p_i,
    output logic [W-1:0] g_o,
    output logic [W-1:0] p_o
);
    localparam int LV = (W > 1) ? $clog2(W) : 0;

    gp_t nd_q [0:LV][W];

    if (TREE == TREE_KS) begin : g_ks
        always_comb begin
            for (int i = 0; i < W; i++) nd_q[0][i] = '{g: g_i[i], p: p_i[i]};
            for (int l = 0; l < LV; l++) begin
                for (int i = 0; i < W; i++) begin
                    if (i >= (1 << l)) nd_q[l+1][i] = gp_join(nd_q[l][i], nd_q[l][i-(1<<l)]);
                    else               nd_q[l+1][i] = nd_q[l][i];
                end
            end
        end
    end else begin : g_lf
        always_comb begin
            for (int i = 0; i < W; i++) nd_q[0][i] = '{g: g_i[i], p: p_i[i]};
            for (int l = 0; l < LV; l++) begin
                for (int i = 0; i < W; i++) begin
                    if (((i >> l) & 1) == 1)
                        nd_q[l+1][i] = gp_join(nd_q[l][i],
                                               nd_q[l][((i >> (l+1)) << (l+1)) + (1 << l) - 1]);
                    else
                        nd_q[l+1][i] = nd_q[l][i];
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            g_o[i] = nd_q[LV][i].g;
            p_o[i] = nd_q[LV][i].p;
        end
    end
endmodule

// File: rtl/sla_cond_group.sv
module sla_cond_group
    import sla_pkg::*;
#(
    parameter int M    = 4,
    parameter int TREE = TREE_KS
) (
    input  logic [M-1:0] g_i,
    input  logic [M-1:0] t_i,
    input  logic [M-1:0] x_i,
    output logic [M-1:0] s0_o,
    output logic [M-1:0] s1_o
);
    logic [M-1:0] lg_d;
    logic [M-1:0] lp_d;
    logic [M-1:0] c0_d;
    logic [M-1:0] c1_d;

    sla_prefix #(.W(M), .TREE(TREE)) u_pfx (
        .g_i (g_i),
        .p_i (t_i),
        .g_o (lg_d),
        .p_o (lp_d)
    );

    // carries into each bit of the group, assuming 0 or 1 enters the group
    always_comb begin
        c0_d[0] = 1'b0;
        c1_d[0] = 1'b1;
        for (int i = 1; i < M; i++) begin
            c0_d[i] = lg_d[i-1];
            c1_d[i] = lg_d[i-1] | lp_d[i-1];
        end
        s0_o = x_i ^ c0_d;
        s1_o = x_i ^ c1_d;
    end
endmodule

// File: rtl/sla_ling_tree.sv
module sla_ling_tree
    import sla_pkg::*;
#(
    parameter int N    = 64,
    parameter int M    = 4,
    parameter int TREE = TREE_KS
) (
    input  logic [N-1:0]   g_i,
    input  logic [N-1:0]   t_i,
    output logic [N/M-1:0] h_o
);
    localparam int NB = N / M;
    localparam int LM = (M > 1) ? $clog2(M) : 0;

    gp_t rd_q [0:LM][N];
    logic [NB-1:0] bg_d;
    logic [NB-1:0] bp_d;

    // phase 1: reduce each block of M Ling pairs (g_i, t_{i-1}) to its top bit
    always_comb begin
        for (int i = 0; i < N; i++) begin
            rd_q[0][i].g = g_i[i];
            rd_q[0][i].p = (i == 0) ? 1'b0 : t_i[(i == 0) ? 0 : i-1];
        end
        for (int l = 0; l < LM; l++) begin
            for (int i = 0; i < N; i++) begin
                if (((i + 1) % (1 << (l+1))) == 0)
                    rd_q[l+1][i] = gp_join(rd_q[l][i], rd_q[l][i-(1<<l)]);
                else
                    rd_q[l+1][i] = rd_q[l][i];
            end
        end
        for (int j = 0; j < NB; j++) begin
            bg_d[j] = rd_q[LM][j*M + M - 1].g;
            bp_d[j] = rd_q[LM][j*M + M - 1].p;
        end
    end

    // phase 2: prefix over block tops
    logic [NB-1:0] hp_d;
    sla_prefix #(.W(NB), .TREE(TREE)) u_blk (
        .g_i (bg_d),
        .p_i (bp_d),
        .g_o (h_o),
        .p_o (hp_d)
    );
endmodule

// File: rtl/sla_adder.sv
module sla_adder
    import sla_pkg::*;
#(
    parameter int WIDTH  = 64,
    parameter int SPARSE = 4,
    parameter int TREE   = TREE_KS
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int NGRP = WIDTH / SPARSE;

    if (!(SPARSE == 1 || SPARSE == 2 || SPARSE == 4 || SPARSE == 8) ||
        (SPARSE > WIDTH / 4) || (WIDTH < 4) || ((WIDTH & (WIDTH - 1)) != 0) ||
        !(TREE == TREE_KS || TREE == TREE_LF)) begin : g_bad_param
        $error("sla_adder: unsupported WIDTH/SPARSE/TREE combination");
    end

    logic [WIDTH-1:0] gen_d;
    logic [WIDTH-1:0] gin_d;
    logic [WIDTH-1:0] tor_d;
    logic [WIDTH-1:0] hxr_d;
    logic [WIDTH-1:0] s0_d;
    logic [WIDTH-1:0] s1_d;
    logic [NGRP-1:0]  h_d;
    logic [NGRP-1:0]  cg_d;

    always_comb begin
        gen_d    = a_i & b_i;
        tor_d    = a_i | b_i;
        hxr_d    = a_i ^ b_i;
        gin_d    = gen_d;
        gin_d[0] = gen_d[0] | (tor_d[0] & cin_i);
    end

    sla_ling_tree #(.N(WIDTH), .M(SPARSE), .TREE(TREE)) u_tree (
        .g_i (gin_d),
        .t_i (tor_d),
        .h_o (h_d)
    );

    // recover real carries at group starts: c = t(prev bit) & h(prev bit)
    always_comb begin
        cg_d[0] = cin_i;
        for (int j = 1; j < NGRP; j++)
            cg_d[j] = tor_d[j*SPARSE - 1] & h_d[j-1];
        cout_o = tor_d[WIDTH-1] & h_d[NGRP-1];
    end

    for (genvar j = 0; j < NGRP; j++) begin : g_grp
        sla_cond_group #(.M(SPARSE), .TREE(TREE)) u_grp (
            .g_i  (gen_d[j*SPARSE +: SPARSE]),
            .t_i  (tor_d[j*SPARSE +: SPARSE]),
            .x_i  (hxr_d[j*SPARSE +: SPARSE]),
            .s0_o (s0_d[j*SPARSE +: SPARSE]),
            .s1_o (s1_d[j*SPARSE +: SPARSE])
        );
        assign sum_o[j*SPARSE +: SPARSE] = cg_d[j] ? s1_d[j*SPARSE +: SPARSE]
                                                    : s0_d[j*SPARSE +: SPARSE];
    end
endmodule

// File: rtl/sla_adder_chk.sv
module sla_adder_chk #(
    parameter int WIDTH = 64
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o
);
    logic [WIDTH:0] ref_d;

    always_comb begin
        ref_d = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        if (!$isunknown({a_i, b_i, cin_i, sum_o, cout_o})) begin
            assert_sum_R1: assert (sum_o == ref_d[WIDTH-1:0]);
            assert_cout_R2: assert (cout_o == ref_d[WIDTH]);
            if (a_i == '0 && b_i == '0)
                assert_zero_R3: assert (sum_o == {{(WIDTH-1){1'b0}}, cin_i} && !cout_o);
            if (b_i == ~a_i)
                assert_prop_R4: assert (sum_o == {WIDTH{~cin_i}} && cout_o == cin_i);
        end
    end
endmodule

bind sla_adder sla_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
);

// File: tb/sim_sla_adder.sv
module sim_sla_adder;
    localparam int W  = 64;
    localparam int NV = 8;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         c;
    } vec_t;

    localparam vec_t TABLE [12] = '{
        '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0},
        '{64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
        '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1},
        '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0},
        '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1},
        '{64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0},
        '{64'h0F0F_0F0F_0F0F_0F0F, 64'h00F0_F0F0_F0F0_F0F1, 1'b0},
        '{64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_9ABC_DEF0, 1'b1},
        '{64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 1'b0},
        '{64'hCCCC_CCCC_CCCC_CCCC, 64'h3333_3333_3333_3333, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b;
    logic         cin;
    logic [W-1:0] sum0;
    logic         cout0;
    logic [W-1:0] vsum [NV];
    logic         vcout [NV];
    logic [7:0]   sa, sb;
    logic         sc;
    logic [7:0]   ssum_ks, ssum_lf;
    logic         scout_ks, scout_lf;
    int           n_chk = 0;
    int           n_err = 0;
    bit           done = 0;

    always #5 clk = ~clk;

    sla_adder u0 (.a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum0), .cout_o(cout0));

    for (genvar k = 0; k < NV; k++) begin : g_var
        sla_adder #(.WIDTH(W), .SPARSE(1 << (k/2)), .TREE(k % 2)) u_dut (
            .a_i(a), .b_i(b), .cin_i(cin), .sum_o(vsum[k]), .cout_o(vcout[k]));
    end

    sla_adder #(.WIDTH(8), .SPARSE(2), .TREE(0)) u_small_ks (
        .a_i(sa), .b_i(sb), .cin_i(sc), .sum_o(ssum_ks), .cout_o(scout_ks));
    sla_adder #(.WIDTH(8), .SPARSE(2), .TREE(1)) u_small_lf (
        .a_i(sa), .b_i(sb), .cin_i(sc), .sum_o(ssum_lf), .cout_o(scout_lf));

    task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h (a=%h b=%h cin=%b)", tag, act, exp, a, b, cin);
        end
    endtask

    // drive inputs, wait to mid-cycle, compare u0 and every variant
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc,
                         input string tag);
        logic [W:0] exp;
        @(posedge clk);
        a = va; b = vb; cin = vc;
        @(negedge clk);
        exp = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
        chk(tag, {cout0, sum0}, exp);
        for (int k = 0; k < NV; k++) begin
            if (k % 2 == 1) chk("R7 tree style", {vcout[k], vsum[k]}, exp);
            else            chk("R6 sparseness", {vcout[k], vsum[k]}, exp);
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [W:0] e;
        a = '0; b = '0; cin = 1'b0; sa = '0; sb = '0; sc = 1'b0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 idle zero", {cout0, sum0}, '0);

        for (int i = 0; i < 12; i++) apply(TABLE[i].a, TABLE[i].b, TABLE[i].c, "R1 table");

        apply('0, '0, 1'b1, "R3 cin only");
        apply('0, '0, 1'b0, "R3 zero");
        apply({W{1'b1}}, '0, 1'b1, "R2 carry out");
        apply({W{1'b1}}, {W{1'b1}}, 1'b1, "R2 max");
        apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, "R4 propagate cin0");
        apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R4 propagate cin1");
        apply(64'h0123_0000_FFFF_1234, ~64'h0123_0000_FFFF_1234, 1'b1, "R4 propagate mixed");

        for (int k = 1; k <= 16; k++) begin
            logic [W-1:0] lo;
            lo = (k == 16) ? {W{1'b1}} : ((64'd1 << (4*k)) - 64'd1);
            apply(lo, 64'd1, 1'b0, "R5 boundary");
            e = {1'b0, lo} + 65'd1;
            chk("R5 exact power", {cout0, sum0}, e);
        end
        for (int k = 1; k < 64; k++) apply((64'd1 << k) - 64'd1, 64'd0, 1'b1, "R5 cin ripple");

        for (int r = 0; r < 1500; r++)
            apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");

        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [8:0] se;
                    sa = 8'(x); sb = 8'(y); sc = 1'(c);
                    #1;
                    se = 9'(x) + 9'(y) + 9'(c);
                    n_chk += 2;
                    if ({scout_ks, ssum_ks} !== se) begin
                        n_err++;
                        $display("FAIL R8 ks: actual=%h expected=%h", {scout_ks, ssum_ks}, se);
                    end
                    if ({scout_lf, ssum_lf} !== se) begin
                        n_err++;
                        $display("FAIL R8 lf: actual=%h expected=%h", {scout_lf, ssum_lf}, se);
                    end
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule